// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block watches the request-tracking tables of a cache-side request sequencer and raises an alarm when a request appears to be stuck. It keeps its own record of every occupied slot in two tables: one for reads, one for writes. For each slot it holds the valid flag, the line address and the time the request entered. The owning logic reports each insertion and each retirement on two small event ports. The time comes from a free-running counter inside the block.

The block stays disarmed while nothing is outstanding. The first insertion arms it. After a fixed threshold it scans the slots, one per cycle: read slots first, then write slots. If any valid entry has been waiting at least the threshold, the block stops and holds a report of that entry. A pass that finds no old entry re-arms the block if anything is still outstanding. Otherwise the block goes back to sleep.

The controller has four named states:

| State | Meaning |
|---|---|
| IDLE | Nothing pending. |
| WAIT | A check is scheduled and the countdown is running. |
| SCAN | A check pass is walking the slots. |
| ALARM | An old entry has been found and its report is held. |

Transitions:

- IDLE to WAIT on a legal insertion (arm).
- WAIT to SCAN when the countdown expires (fire).
- SCAN to ALARM on an old entry (trip).
- SCAN to WAIT after the last slot if anything is outstanding (re-arm).
- SCAN to IDLE after the last slot otherwise (sleep).
- ALARM holds until reset.

Top module: `req_age_watchdog`

## Requirements
- R1: After reset, `alarm` and `armed` are 0, all report outputs are 0, both tables are empty and the time counter is 0.
- R2: The time counter advances by one on every clock edge outside reset. Call its value during a cycle t. A legal insertion sampled at the edge that ends cycle t, while the block is idle (neither armed nor alarmed), sets `armed` to 1 from cycle t+1. The first pass then examines its first slot in cycle t+THRESH+1.
- R3: An insertion writes valid=1, the address and the stamp t into the slot selected by `ins_table` (0 = read, 1 = write) and `ins_slot`. A removal clears the selected slot's valid flag. When both target the same slot in one cycle, the insertion wins. A slot index at or beyond that table's depth is ignored entirely and does not arm the block.
- R4: A pass examines one slot per cycle in this order: read slots 0 to RD_SLOTS-1, then write slots 0 to WR_SLOTS-1. An entry trips the alarm when it is valid and its age is greater than or equal to THRESH. An age of exactly THRESH trips it; THRESH-1 does not. The first tripping entry in pass order is the one reported.
- R5: Age is (current time - issue stamp) modulo 2^TS_W, so a stamp taken before the counter wraps still yields the true age. THRESH must be at least 1 and below 2^(TS_W-1).
- R6: From the cycle after the tripping slot is examined, the report outputs hold the following values:
  - `alarm_table` and `alarm_slot`: where the entry sits.
  - `alarm_addr`: its line address.
  - `alarm_occ`: the number of valid entries in that table during the examining cycle.
  - `alarm_now`: the time during that cycle.
  - `alarm_issue`: the entry's stamp.
  - `alarm_age`: their modular difference.
- R7: Suppose a pass finds no old entry and its last slot is examined in cycle c. If any entry is valid in cycle c, or a legal insertion arrives at its closing edge, the next pass examines its first slot in cycle c+THRESH+1. Otherwise `armed` falls to 0 from cycle c+1.
- R8: Once raised, `alarm` stays 1 and every report output stays unchanged until reset, whatever insertions or removals arrive. `armed` is 0 while `alarm` is 1.
- R9: Insertions that arrive while a check is already scheduled or a pass is running do not move the scheduled check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insertion event this cycle |
| ins_table | input | 1 | Insertion table: 0 read, 1 write |
| ins_slot | input | SLOT_W | Insertion slot index |
| ins_addr | input | ADDR_W | Line address of the inserted request |
| rm_valid | input | 1 | Retirement event this cycle |
| rm_table | input | 1 | Retirement table: 0 read, 1 write |
| rm_slot | input | SLOT_W | Retirement slot index |
| armed | output | 1 | A check is scheduled or a pass is running |
| alarm | output | 1 | Sticky stuck-request alarm |
| alarm_table | output | 1 | Table of the reported entry |
| alarm_slot | output | SLOT_W | Slot of the reported entry |
| alarm_addr | output | ADDR_W | Line address of the reported entry |
| alarm_occ | output | OCC_W | Occupancy of that table when examined |
| alarm_now | output | TS_W | Time when the entry was examined |
| alarm_issue | output | TS_W | Issue stamp of the entry |
| alarm_age | output | TS_W | Age of the entry when examined |

## Verification
Each result has its own due time:

- `armed` appears one cycle after the arming insertion.
- A pass begins THRESH+1 cycles after its arming edge.
- The report for the slot at pass position i appears one cycle after that slot's examining cycle.
- A pass with no hit that follows THRESH cycles after the previous one begins S+THRESH cycles after it, where S is the total number of slots.

The bench reads a cycle counter that matches the time base. A bench function walks the passes over the bench's own model of the tables and predicts the exact cycle of the trip or of the fall of `armed`. The bench then confirms that `alarm` stays low up to that cycle and samples every output on the falling edge of the cycle where it is due.

// File: rtl/raw_pkg.sv
package raw_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_WAIT  = 2'd1,
        WD_SCAN  = 2'd2,
        WD_ALARM = 2'd3
    } wd_state_e;

    localparam logic TBL_RD = 1'b0;
    localparam logic TBL_WR = 1'b1;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/raw_timebase.sv
module raw_timebase #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now <= '0;
        end else begin
            now <= now + TS_W'(1);
        end
    end

endmodule

// File: rtl/raw_entry_bank.sv
module raw_entry_bank #(
    parameter int DEPTH  = 4,
    parameter int SLOT_W = 2,
    parameter int ADDR_W = 16,
    parameter int TS_W   = 16,
    parameter int OCC_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_en,
    input  logic [SLOT_W-1:0]            ins_slot,
    input  logic [ADDR_W-1:0]            ins_addr,
    input  logic [TS_W-1:0]              stamp,
    input  logic                         rm_en,
    input  logic [SLOT_W-1:0]            rm_slot,
    output logic [DEPTH-1:0]             valid,
    output logic [DEPTH-1:0][ADDR_W-1:0] addr,
    output logic [DEPTH-1:0][TS_W-1:0]   issue,
    output logic [OCC_W-1:0]             occ
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              ins_hit;
        logic              rm_hit;
        logic              v_q;
        logic [ADDR_W-1:0] a_q;
        logic [TS_W-1:0]   t_q;

        assign ins_hit = ins_en && (ins_slot == SLOT_W'(g));
        assign rm_hit  = rm_en  && (rm_slot  == SLOT_W'(g));

        // a simultaneous insert and retire on one slot keeps the insert
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                a_q <= '0;
                t_q <= '0;
            end else if (ins_hit) begin
                v_q <= 1'b1;
                a_q <= ins_addr;
                t_q <= stamp;
            end else if (rm_hit) begin
                v_q <= 1'b0;
            end
        end

        assign valid[g] = v_q;
        assign addr[g]  = a_q;
        assign issue[g] = t_q;
    end

    always_comb begin
        occ = '0;
        for (int i = 0; i < DEPTH; i++) begin
            occ = occ + OCC_W'(valid[i]);
        end
    end

endmodule

// File: rtl/raw_scan_sel.sv
module raw_scan_sel import raw_pkg::*; #(
    parameter int RD_SLOTS = 4,
    parameter int WR_SLOTS = 4,
    parameter int IDX_W    = 3,
    parameter int SLOT_W   = 2,
    parameter int ADDR_W   = 16,
    parameter int TS_W     = 16,
    parameter int OCC_W    = 3
) (
    input  logic [IDX_W-1:0]                idx,
    input  logic [RD_SLOTS-1:0]             rd_valid,
    input  logic [RD_SLOTS-1:0][ADDR_W-1:0] rd_addr,
    input  logic [RD_SLOTS-1:0][TS_W-1:0]   rd_issue,
    input  logic [OCC_W-1:0]                rd_occ,
    input  logic [WR_SLOTS-1:0]             wr_valid,
    input  logic [WR_SLOTS-1:0][ADDR_W-1:0] wr_addr,
    input  logic [WR_SLOTS-1:0][TS_W-1:0]   wr_issue,
    input  logic [OCC_W-1:0]                wr_occ,
    output logic                            sel_valid,
    output logic                            sel_table,
    output logic [SLOT_W-1:0]               sel_slot,
    output logic [ADDR_W-1:0]               sel_addr,
    output logic [TS_W-1:0]                 sel_issue,
    output logic [OCC_W-1:0]                sel_occ
);

    // pass position i: read slots occupy 0..RD-1, write slots follow
    always_comb begin
        sel_valid = 1'b0;
        sel_table = TBL_RD;
        sel_slot  = '0;
        sel_addr  = '0;
        sel_issue = '0;
        sel_occ   = '0;
        for (int i = 0; i < RD_SLOTS; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_valid = rd_valid[i];
                sel_table = TBL_RD;
                sel_slot  = SLOT_W'(i);
                sel_addr  = rd_addr[i];
                sel_issue = rd_issue[i];
                sel_occ   = rd_occ;
            end
        end
        for (int j = 0; j < WR_SLOTS; j++) begin
            if (idx == IDX_W'(RD_SLOTS + j)) begin
                sel_valid = wr_valid[j];
                sel_table = TBL_WR;
                sel_slot  = SLOT_W'(j);
                sel_addr  = wr_addr[j];
                sel_issue = wr_issue[j];
                sel_occ   = wr_occ;
            end
        end
    end

endmodule

// File: rtl/req_age_watchdog.sv
module req_age_watchdog import raw_pkg::*; #(
    parameter int ADDR_W   = 16,
    parameter int RD_SLOTS = 8,
    parameter int WR_SLOTS = 8,
    parameter int TS_W     = 16,
    parameter int THRESH   = 1000,
    localparam int MAXD    = max_of(RD_SLOTS, WR_SLOTS),
    localparam int SLOT_W  = bits_for(MAXD),
    localparam int OCC_W   = $clog2(MAXD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_table,
    input  logic [SLOT_W-1:0] ins_slot,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              rm_valid,
    input  logic              rm_table,
    input  logic [SLOT_W-1:0] rm_slot,
    output logic              armed,
    output logic              alarm,
    output logic              alarm_table,
    output logic [SLOT_W-1:0] alarm_slot,
    output logic [ADDR_W-1:0] alarm_addr,
    output logic [OCC_W-1:0]  alarm_occ,
    output logic [TS_W-1:0]   alarm_now,
    output logic [TS_W-1:0]   alarm_issue,
    output logic [TS_W-1:0]   alarm_age
);

    localparam int TOTAL = RD_SLOTS + WR_SLOTS;
    localparam int IDX_W = bits_for(TOTAL);
    localparam int TMR_W = $clog2(THRESH + 1);
    localparam logic [TS_W-1:0]  THR_TS   = TS_W'(THRESH);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(THRESH - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TOTAL - 1);

    // ---------------- time base ----------------
    logic [TS_W-1:0] now;

    raw_timebase #(.TS_W(TS_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    // ---------------- event qualification ----------------
    logic ins_in_range;
    logic ins_ok;
    logic rd_ins_en, wr_ins_en, rd_rm_en, wr_rm_en;

    always_comb begin
        if (ins_table == TBL_WR) begin
            ins_in_range = int'(ins_slot) < WR_SLOTS;
        end else begin
            ins_in_range = int'(ins_slot) < RD_SLOTS;
        end
    end

    assign ins_ok    = ins_valid && ins_in_range;
    assign rd_ins_en = ins_valid && (ins_table == TBL_RD);
    assign wr_ins_en = ins_valid && (ins_table == TBL_WR);
    assign rd_rm_en  = rm_valid  && (rm_table  == TBL_RD);
    assign wr_rm_en  = rm_valid  && (rm_table  == TBL_WR);

    // ---------------- shadow tables ----------------
    logic [RD_SLOTS-1:0]             rd_valid;
    logic [RD_SLOTS-1:0][ADDR_W-1:0] rd_addr;
    logic [RD_SLOTS-1:0][TS_W-1:0]   rd_issue;
    logic [OCC_W-1:0]                rd_occ;
    logic [WR_SLOTS-1:0]             wr_valid;
    logic [WR_SLOTS-1:0][ADDR_W-1:0] wr_addr;
    logic [WR_SLOTS-1:0][TS_W-1:0]   wr_issue;
    logic [OCC_W-1:0]                wr_occ;

    raw_entry_bank #(
        .DEPTH(RD_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
        .TS_W(TS_W), .OCC_W(OCC_W)
    ) u_rd_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (rd_ins_en),
        .ins_slot (ins_slot),
        .ins_addr (ins_addr),
        .stamp    (now),
        .rm_en    (rd_rm_en),
        .rm_slot  (rm_slot),
        .valid    (rd_valid),
        .addr     (rd_addr),
        .issue    (rd_issue),
        .occ      (rd_occ)
    );

    raw_entry_bank #(
        .DEPTH(WR_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
        .TS_W(TS_W), .OCC_W(OCC_W)
    ) u_wr_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (wr_ins_en),
        .ins_slot (ins_slot),
        .ins_addr (ins_addr),
        .stamp    (now),
        .rm_en    (wr_rm_en),
        .rm_slot  (rm_slot),
        .valid    (wr_valid),
        .addr     (wr_addr),
        .issue    (wr_issue),
        .occ      (wr_occ)
    );

    // ---------------- pass position select ----------------
    logic [IDX_W-1:0]  idx_q;
    logic              sel_valid;
    logic              sel_table;
    logic [SLOT_W-1:0] sel_slot;
    logic [ADDR_W-1:0] sel_addr;
    logic [TS_W-1:0]   sel_issue;
    logic [OCC_W-1:0]  sel_occ;

    raw_scan_sel #(
        .RD_SLOTS(RD_SLOTS), .WR_SLOTS(WR_SLOTS), .IDX_W(IDX_W),
        .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .OCC_W(OCC_W)
    ) u_sel (
        .idx       (idx_q),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_issue  (rd_issue),
        .rd_occ    (rd_occ),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_issue  (wr_issue),
        .wr_occ    (wr_occ),
        .sel_valid (sel_valid),
        .sel_table (sel_table),
        .sel_slot  (sel_slot),
        .sel_addr  (sel_addr),
        .sel_issue (sel_issue),
        .sel_occ   (sel_occ)
    );

    // modular age survives a counter wrap
    logic [TS_W-1:0] sel_age;
    logic            sel_old;
    logic            pass_last;
    logic            any_pending;

    assign sel_age     = now - sel_issue;
    assign sel_old     = sel_valid && (sel_age >= THR_TS);
    assign pass_last   = (idx_q == IDX_LAST);
    assign any_pending = (|rd_valid) || (|wr_valid) || ins_ok;

    // ---------------- controller ----------------
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [TMR_W-1:0] tmr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (ins_ok) state_d = WD_WAIT;              // arm
            end
            WD_WAIT: begin
                if (tmr_q == '0) state_d = WD_SCAN;         // fire
            end
            WD_SCAN: begin
                if (sel_old) begin
                    state_d = WD_ALARM;                     // trip
                end else if (pass_last) begin
                    state_d = any_pending ? WD_WAIT         // re-arm
                                          : WD_IDLE;        // sleep
                end
            end
            WD_ALARM: state_d = WD_ALARM;
            default:  state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        armed = 1'b0;
        alarm = 1'b0;
        unique case (state_q)
            WD_IDLE:  begin armed = 1'b0; alarm = 1'b0; end
            WD_WAIT:  begin armed = 1'b1; alarm = 1'b0; end
            WD_SCAN:  begin armed = 1'b1; alarm = 1'b0; end
            WD_ALARM: begin armed = 1'b0; alarm = 1'b1; end
            default:  begin armed = 1'b0; alarm = 1'b0; end
        endcase
    end

    // ---------------- countdown and pass position ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
            idx_q <= '0;
        end else begin
            if (state_q != WD_WAIT && state_d == WD_WAIT) begin
                tmr_q <= TMR_LOAD;
            end else if (state_q == WD_WAIT && tmr_q != '0) begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
            if (state_q == WD_SCAN) begin
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                idx_q <= '0;
            end
        end
    end

    // ---------------- report capture ----------------
    logic              cap_table;
    logic [SLOT_W-1:0] cap_slot;
    logic [ADDR_W-1:0] cap_addr;
    logic [OCC_W-1:0]  cap_occ;
    logic [TS_W-1:0]   cap_now;
    logic [TS_W-1:0]   cap_issue;
    logic [TS_W-1:0]   cap_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_table <= TBL_RD;
            cap_slot  <= '0;
            cap_addr  <= '0;
            cap_occ   <= '0;
            cap_now   <= '0;
            cap_issue <= '0;
            cap_age   <= '0;
        end else if (state_q == WD_SCAN && sel_old) begin
            cap_table <= sel_table;
            cap_slot  <= sel_slot;
            cap_addr  <= sel_addr;
            cap_occ   <= sel_occ;
            cap_now   <= now;
            cap_issue <= sel_issue;
            cap_age   <= sel_age;
        end
    end

    assign alarm_table = cap_table;
    assign alarm_slot  = cap_slot;
    assign alarm_addr  = cap_addr;
    assign alarm_occ   = cap_occ;
    assign alarm_now   = cap_now;
    assign alarm_issue = cap_issue;
    assign alarm_age   = cap_age;

endmodule

// File: rtl/req_age_watchdog_chk.sv
module req_age_watchdog_chk #(
    parameter int ADDR_W   = 16,
    parameter int RD_SLOTS = 8,
    parameter int WR_SLOTS = 8,
    parameter int TS_W     = 16,
    parameter int THRESH   = 1000,
    parameter int SLOT_W   = 3,
    parameter int OCC_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_valid,
    input logic              ins_table,
    input logic [SLOT_W-1:0] ins_slot,
    input logic              armed,
    input logic              alarm,
    input logic              alarm_table,
    input logic [SLOT_W-1:0] alarm_slot,
    input logic [ADDR_W-1:0] alarm_addr,
    input logic [OCC_W-1:0]  alarm_occ,
    input logic [TS_W-1:0]   alarm_now,
    input logic [TS_W-1:0]   alarm_issue,
    input logic [TS_W-1:0]   alarm_age
);

    logic legal_ins;
    int   rep_depth;

    assign legal_ins = ins_valid &&
                       (int'(ins_slot) < (ins_table ? WR_SLOTS : RD_SLOTS));
    assign rep_depth = alarm_table ? WR_SLOTS : RD_SLOTS;

    // R2: an idle block arms on a legal insertion
    p_arm_on_insert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !alarm && legal_ins) |=> armed);

    // R4: a freshly raised alarm reports an entry at least THRESH old
    p_age_reaches_thresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> (alarm_age >= TS_W'(THRESH)));

    // R5: reported age matches the reported stamps modulo the counter width
    p_age_modular_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (TS_W'(alarm_now - alarm_issue) == alarm_age));

    // R6: reported slot and occupancy fit the reported table
    p_report_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> ((int'(alarm_slot) < rep_depth) && (alarm_occ != '0) &&
                   (int'(alarm_occ) <= rep_depth)));

    // R8: alarm stays raised
    p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

    // R8: report frozen while alarmed
    p_report_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> ($stable(alarm_addr) && $stable(alarm_table) &&
                   $stable(alarm_slot) && $stable(alarm_occ) &&
                   $stable(alarm_now) && $stable(alarm_issue) &&
                   $stable(alarm_age)));

    // R8: never armed and alarmed together
    p_alarm_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> !armed);

endmodule

bind req_age_watchdog req_age_watchdog_chk #(
    .ADDR_W(ADDR_W), .RD_SLOTS(RD_SLOTS), .WR_SLOTS(WR_SLOTS),
    .TS_W(TS_W), .THRESH(THRESH), .SLOT_W(SLOT_W), .OCC_W(OCC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .ins_table   (ins_table),
    .ins_slot    (ins_slot),
    .armed       (armed),
    .alarm       (alarm),
    .alarm_table (alarm_table),
    .alarm_slot  (alarm_slot),
    .alarm_addr  (alarm_addr),
    .alarm_occ   (alarm_occ),
    .alarm_now   (alarm_now),
    .alarm_issue (alarm_issue),
    .alarm_age   (alarm_age)
);

// File: tb/req_age_watchdog_bench.sv
`timescale 1ns/1ps
module req_age_watchdog_bench;

    localparam int ADDR_W = 16;
    localparam int RD     = 4;
    localparam int WR     = 3;
    localparam int TS_W   = 8;
    localparam int THR    = 24;
    localparam int S      = RD + WR;
    localparam int SLOT_W = 2;
    localparam int OCC_W  = 3;
    localparam int TSMOD  = 1 << TS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              ins_valid = 1'b0, ins_table = 1'b0;
    logic [SLOT_W-1:0] ins_slot = '0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic              rm_valid = 1'b0, rm_table = 1'b0;
    logic [SLOT_W-1:0] rm_slot = '0;
    logic              armed, alarm, alarm_table;
    logic [SLOT_W-1:0] alarm_slot;
    logic [ADDR_W-1:0] alarm_addr;
    logic [OCC_W-1:0]  alarm_occ;
    logic [TS_W-1:0]   alarm_now, alarm_issue, alarm_age;

    always #2.5 clk = ~clk;

    req_age_watchdog #(
        .ADDR_W(ADDR_W), .RD_SLOTS(RD), .WR_SLOTS(WR), .TS_W(TS_W), .THRESH(THR)
    ) u_req_age_watchdog (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_table(ins_table), .ins_slot(ins_slot),
        .ins_addr(ins_addr), .rm_valid(rm_valid), .rm_table(rm_table),
        .rm_slot(rm_slot), .armed(armed), .alarm(alarm),
        .alarm_table(alarm_table), .alarm_slot(alarm_slot),
        .alarm_addr(alarm_addr), .alarm_occ(alarm_occ), .alarm_now(alarm_now),
        .alarm_issue(alarm_issue), .alarm_age(alarm_age)
    );

    // bench cycle count; equals the expected time value in each cycle
    int ecnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    bit m_v [2][4];
    int m_a [2][4];
    int m_t [2][4];

    bit e_hit;
    int e_tab, e_slot, e_now, e_issue, e_addr, e_occ, e_idle;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input longint act, input longint exp);
        check(act == exp, req, what, act, exp);
    endtask

    function automatic int depth_of(input int t);
        return (t != 0) ? WR : RD;
    endfunction

    task automatic do_reset();
        ins_valid = 0; rm_valid = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++) m_v[t][s] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one cycle of events; model: retire first, then insert (insert wins)
    task automatic drive(input bit iv, input int it, input int is, input int ia,
                         input bit rv, input int rt, input int rs);
        ins_valid = iv; ins_table = it[0]; ins_slot = is[SLOT_W-1:0];
        ins_addr = ia[ADDR_W-1:0];
        rm_valid = rv; rm_table = rt[0]; rm_slot = rs[SLOT_W-1:0];
        if (rv && rs < depth_of(rt)) m_v[rt][rs] = 1'b0;
        if (iv && is < depth_of(it)) begin
            m_v[it][is] = 1'b1;
            m_a[it][is] = ia & 32'hFFFF;
            m_t[it][is] = ecnt;
        end
        @(negedge clk);
        ins_valid = 0; rm_valid = 0;
    endtask

    // walk the passes over the frozen model
    task automatic predict(input int e0);
        int p;
        bit any;
        p = e0 + THR + 1;
        e_hit = 1'b0;
        e_idle = -1;
        for (int pass = 0; pass < 3 && !e_hit && e_idle < 0; pass++) begin
            any = 1'b0;
            for (int i = 0; i < S && !e_hit; i++) begin
                int t, s, nw;
                t = (i < RD) ? 0 : 1;
                s = (i < RD) ? i : i - RD;
                nw = p + i;
                if (m_v[t][s]) any = 1'b1;
                if (m_v[t][s] && (nw - m_t[t][s]) >= THR) begin
                    e_hit = 1'b1; e_tab = t; e_slot = s; e_now = nw;
                    e_issue = m_t[t][s]; e_addr = m_a[t][s];
                    e_occ = 0;
                    for (int k = 0; k < depth_of(t); k++) e_occ += int'(m_v[t][k]);
                end
            end
            if (!e_hit) begin
                if (!any) e_idle = p + S;
                p = p + S + THR;
            end
        end
    endtask

    task automatic run_check(input string tag);
        bit early;
        early = 1'b0;
        if (e_hit) begin
            while (ecnt < e_now + 1) begin
                if (alarm) early = 1'b1;
                @(negedge clk);
            end
            chk_eq("R4", {tag, " no alarm before due cycle"}, early, 0);
            chk_eq("R4", {tag, " alarm raised"}, alarm, 1);
            chk_eq("R6", {tag, " table"}, alarm_table, e_tab);
            chk_eq("R6", {tag, " slot"}, alarm_slot, e_slot);
            chk_eq("R6", {tag, " addr"}, alarm_addr, e_addr);
            chk_eq("R6", {tag, " occupancy"}, alarm_occ, e_occ);
            chk_eq("R5", {tag, " now"}, alarm_now, e_now % TSMOD);
            chk_eq("R5", {tag, " issue"}, alarm_issue, e_issue % TSMOD);
            chk_eq("R5", {tag, " age"}, alarm_age, e_now - e_issue);
        end else begin
            while (ecnt < e_idle - 1) begin
                if (alarm) early = 1'b1;
                @(negedge clk);
            end
            chk_eq("R7", {tag, " no alarm on empty tables"}, early, 0);
            chk_eq("R7", {tag, " armed during last slot"}, armed, 1);
            @(negedge clk);
            chk_eq("R7", {tag, " disarmed after pass"}, armed, 0);
            chk_eq("R7", {tag, " alarm low"}, alarm, 0);
        end
    endtask

    initial begin : main
        int e0;
        void'($urandom(32'h5EED_0042));
        do_reset();

        // R1: reset state
        chk_eq("R1", "alarm after reset", alarm, 0);
        chk_eq("R1", "armed after reset", armed, 0);
        chk_eq("R1", "addr after reset", alarm_addr, 0);
        chk_eq("R1", "age after reset", alarm_age, 0);
        idle(5);
        chk_eq("R1", "armed stays low with no events", armed, 0);

        // R3: out-of-range write slot is ignored and does not arm
        drive(1, 1, 3, 16'h55AA, 0, 0, 0);
        chk_eq("R3", "out-of-range insert arms", armed, 0);

        // R7: insert then retire before the check -> sleep
        do_reset(); idle(2);
        e0 = ecnt;
        drive(1, 0, 1, 16'h1111, 0, 0, 0);
        chk_eq("R2", "armed after first insert", armed, 1);
        idle(3);
        drive(0, 0, 0, 0, 1, 0, 1);
        predict(e0);
        run_check("empty-pass");

        // R9: late insert does not move the check; first pass misses, second trips
        do_reset();
        e0 = ecnt;
        drive(1, 0, 0, 16'h2222, 0, 0, 0);
        idle(THR - 5);
        drive(1, 1, 2, 16'h3333, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        predict(e0);
        chk_eq("R9", "second-pass hit predicted", e_now > e0 + THR + S, 1);
        run_check("R9 late-insert");

        // R3 insert-wins and R4 age exactly THRESH
        do_reset();
        e0 = ecnt;
        drive(1, 0, 2, 16'hAAAA, 0, 0, 0);
        idle(2);
        drive(1, 0, 2, 16'hBBBB, 1, 0, 2);
        predict(e0);
        run_check("R3 insert-wins");
        chk_eq("R4", "boundary age equals threshold", alarm_age, THR);
        chk_eq("R3", "replacing address kept", alarm_addr, 16'hBBBB);

        // R5: stamps across a counter wrap
        do_reset();
        idle(250);
        e0 = ecnt;
        drive(1, 1, 0, 16'hCAFE, 0, 0, 0);
        predict(e0);
        run_check("R5 wrap");
        chk_eq("R5", "now wrapped below issue", alarm_now < alarm_issue, 1);

        // R8: sticky alarm and frozen report
        begin
            int sv_addr, sv_now, sv_age;
            sv_addr = alarm_addr; sv_now = alarm_now; sv_age = alarm_age;
            for (int k = 0; k < 20; k++)
                drive(1, k % 2, k % 3, k * 7, 1, (k + 1) % 2, k % 3);
            chk_eq("R8", "alarm held", alarm, 1);
            chk_eq("R8", "armed low while alarmed", armed, 0);
            chk_eq("R8", "addr frozen", alarm_addr, sv_addr);
            chk_eq("R8", "now frozen", alarm_now, sv_now);
            chk_eq("R8", "age frozen", alarm_age, sv_age);
            do_reset();
            chk_eq("R8", "reset clears alarm", alarm, 0);
        end

        // constrained random trials
        for (int trial = 0; trial < 12; trial++) begin
            do_reset();
            idle($urandom_range(0, 300));
            e0 = ecnt;
            begin
                int t0;
                t0 = $urandom_range(0, 1);
                drive(1, t0, $urandom_range(0, depth_of(t0) - 1),
                      $urandom_range(0, 65535), 0, 0, 0);
            end
            chk_eq("R2", "random arm", armed, 1);
            for (int w = 1; w <= THR - 3; w++) begin
                int op, it, rt;
                op = $urandom_range(0, 3);
                it = $urandom_range(0, 1);
                rt = $urandom_range(0, 1);
                drive(op[0], it, $urandom_range(0, depth_of(it) - 1),
                      $urandom_range(0, 65535),
                      op[1], rt, $urandom_range(0, depth_of(rt) - 1));
            end
            predict(e0);
            run_check("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule